// File: doc/BRIEF.md
# Time-Slot Synchronous Transfer Unit

This block copies one byte per frame from a selected receive time-slot into a selected transmit time-slot, separately for each of two channels. It sits between the bit-serial receive and transmit lines of two TDM highways: a trunk-side highway and a line-side highway. An external framer supplies a one-cycle bit strobe together with the slot number and the bit position within the slot. Each channel is programmed through a small processor port with a source slot and highway, a destination slot and highway, and an enable bit.

During each frame the bits of the source slot are shifted into a per-channel holding register, most significant bit first. When the destination slot begins, the holding register is loaded into a transmit shifter and driven out with its output enable raised. Because the holding register can be read and written from the processor port, software can inspect the switched byte or replace it before it leaves. A per-channel capture flag marks that a new byte has arrived since the last read.

Top module: `slot_xfer_unit`

## Requirements
- R1: After reset, both output enables are low, `cpu_rdata` is 0x00, every channel is disabled, and every holding register, capture flag and configuration register reads 0x00.
- R2: Processor address = {channel, reg[1:0]}. reg 0 is the source setting: bits [4:0] slot, bit 6 enable, bit 7 highway (0 trunk, 1 line). reg 1 is the destination setting: bits [4:0] slot, bit 7 highway. reg 2 is the holding register. reg 3 is status, with the capture flag in bit 0. A read presented with `cpu_re` appears on `cpu_rdata` one clock later and is held until the next read.
- R3: For an enabled channel, the source slot's bits are taken MSB first at the bit strobes with positions 0 to 7. After the strobe at position 7 the holding register contains the byte and the capture flag is 1.
- R4: In the destination slot, the chosen highway's output carries the holding register MSB first. The data output changes only on bit strobes. The output enable is high for exactly the eight bit periods of that slot, and only when the slot started while the channel was enabled.
- R5: Source and destination are independent: any slot and either highway for each, including crossing from one highway to the other.
- R6: A processor write to the holding register that lands after capture and before the destination slot's first strobe is the byte transmitted.
- R7: When the destination slot precedes the source slot in the frame, the byte transmitted is the one captured in the previous frame.
- R8: While a channel is disabled its destination output enable stays low, and its holding register and capture flag are not changed by received data.
- R9: Reading the holding register clears the capture flag. A read in the same clock as a capture returns the old byte and leaves the flag set.
- R10: The two channels capture and transmit independently. When both target the same highway and slot, channel 0 drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per highway bit period |
| slot_num | input | 5 | Slot index of the current bit |
| bit_num | input | 3 | Bit position in the slot, 0 is the MSB |
| trk_rx | input | 1 | Trunk highway receive data |
| lin_rx | input | 1 | Line highway receive data |
| trk_tx | output | 1 | Trunk highway transmit data |
| trk_oe | output | 1 | Trunk highway output enable |
| lin_tx | output | 1 | Line highway transmit data |
| lin_oe | output | 1 | Line highway output enable |
| cpu_we | input | 1 | Processor write strobe |
| cpu_re | input | 1 | Processor read strobe |
| cpu_addr | input | 3 | Processor address {channel, reg} |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data, registered |

## Verification
The hardest case to reach is a holding-register read that lands in the same clock as the bit-7 strobe of the source slot. That one clock decides whether the fresh-data flag survives. The bench hooks the processor task onto the framer's strobe event, so `cpu_re` is raised in the same half-cycle as that strobe. It then checks that the old byte is returned and the flag stays set. Frame-order effects get similar care. A destination placed before its source, a processor overwrite placed between capture and transmit, and two channels contending for one slot are each set up at a known frame start. The bytes they must produce are queued in advance for a monitor that rebuilds every driven slot.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W);
  // Field positions in the source/destination setting bytes
  localparam int IF_BIT = 7;
  localparam int EN_BIT = 6;

  typedef enum logic {IF_TRUNK = 1'b0, IF_LINE = 1'b1} iface_e;

  typedef enum logic [1:0] {
    REG_SRC  = 2'd0,
    REG_DST  = 2'd1,
    REG_DATA = 2'd2,
    REG_STAT = 2'd3
  } reg_e;
endpackage

// File: rtl/xfer_channel.sv
module xfer_channel
  import xfer_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic [SLOT_W-1:0] slot_num,
  input  logic [BIT_W-1:0]  bit_num,
  input  logic              trk_rx,
  input  logic              lin_rx,
  input  logic              src_we,
  input  logic              dst_we,
  input  logic              data_we,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] src_rb,
  output logic [BYTE_W-1:0] dst_rb,
  output logic [BYTE_W-1:0] data_q,
  output logic              cap_flag,
  output logic              tx_bit,
  output logic              tx_act,
  output logic              tx_if
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic [SLOT_W-1:0] src_slot, dst_slot;
  iface_e            src_if, dst_if;
  logic              ch_en;

  // Channel settings
  always_ff @(posedge clk) begin
    if (rst) begin
      src_slot <= '0;
      dst_slot <= '0;
      src_if   <= IF_TRUNK;
      dst_if   <= IF_TRUNK;
      ch_en    <= 1'b0;
    end else begin
      if (src_we) begin
        src_slot <= wdata[SLOT_W-1:0];
        src_if   <= iface_e'(wdata[IF_BIT]);
        ch_en    <= wdata[EN_BIT];
      end
      if (dst_we) begin
        dst_slot <= wdata[SLOT_W-1:0];
        dst_if   <= iface_e'(wdata[IF_BIT]);
      end
    end
  end

  always_comb begin
    src_rb                 = '0;
    src_rb[SLOT_W-1:0]     = src_slot;
    src_rb[EN_BIT]         = ch_en;
    src_rb[IF_BIT]         = (src_if == IF_LINE);
    dst_rb                 = '0;
    dst_rb[SLOT_W-1:0]     = dst_slot;
    dst_rb[IF_BIT]         = (dst_if == IF_LINE);
  end

  // Capture side
  logic              rx_bit, in_src, cap_done;
  logic [BYTE_W-2:0] cap_sh;

  assign rx_bit   = (src_if == IF_LINE) ? lin_rx : trk_rx;
  assign in_src   = bit_tick && ch_en && (slot_num == src_slot);
  assign cap_done = in_src && (bit_num == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst)         cap_sh <= '0;
    else if (in_src) cap_sh <= {cap_sh[BYTE_W-3:0], rx_bit};
  end

  // Holding register: a completed capture takes precedence over a write
  always_ff @(posedge clk) begin
    if (rst)           data_q <= '0;
    else if (cap_done) data_q <= {cap_sh, rx_bit};
    else if (data_we)  data_q <= wdata;
  end

  // Fresh-data flag: setting beats the read-clear
  always_ff @(posedge clk) begin
    if (rst)           cap_flag <= 1'b0;
    else if (cap_done) cap_flag <= 1'b1;
    else if (data_rd)  cap_flag <= 1'b0;
  end

  // Transmit side: snapshot at every slot start, drive only in the destination slot
  logic [BYTE_W-2:0] tx_sh;
  logic              slot_first, at_dst;

  assign slot_first = (bit_num == '0);
  assign at_dst     = (slot_num == dst_slot);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_act <= 1'b0;
      tx_bit <= 1'b0;
      tx_sh  <= '0;
      tx_if  <= 1'b0;
    end else if (bit_tick) begin
      tx_act <= ch_en && at_dst && (slot_first || tx_act);
      if (slot_first) begin
        {tx_bit, tx_sh} <= data_q;
        tx_if           <= (dst_if == IF_LINE);
      end else begin
        {tx_bit, tx_sh} <= {tx_sh, 1'b0};
      end
    end
  end

  a_r3_flag_from_capture: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_flag) |-> $past(bit_tick && ch_en && bit_num == LAST_BIT));

  a_r6_data_holds: assert property (@(posedge clk) disable iff (rst)
    (!data_we && !cap_done) |=> $stable(data_q));

  a_r4_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> ($stable(tx_act) && $stable(tx_bit)));

  a_r4_full_slot: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_act) |-> ($past(bit_num) == '0));

  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && !ch_en) |=> !tx_act);

  a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !cap_done) |=> !cap_flag);
endmodule

// File: rtl/xfer_tx_merge.sv
module xfer_tx_merge #(
  parameter int NUM_CH = 2
) (
  input  logic [NUM_CH-1:0] tx_bit,
  input  logic [NUM_CH-1:0] tx_act,
  input  logic [NUM_CH-1:0] tx_if,
  output logic              trk_tx,
  output logic              trk_oe,
  output logic              lin_tx,
  output logic              lin_oe
);
  // Scan from the highest channel down so the lowest index wins a collision
  always_comb begin
    trk_tx = 1'b0;
    trk_oe = 1'b0;
    lin_tx = 1'b0;
    lin_oe = 1'b0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (tx_act[c]) begin
        if (tx_if[c]) begin
          lin_oe = 1'b1;
          lin_tx = tx_bit[c];
        end else begin
          trk_oe = 1'b1;
          trk_tx = tx_bit[c];
        end
      end
    end
  end
endmodule

// File: rtl/xfer_host_if.sv
module xfer_host_if
  import xfer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1,
  parameter int ADDR_W = CH_W + 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cpu_we,
  input  logic                           cpu_re,
  input  logic [ADDR_W-1:0]              cpu_addr,
  input  logic [NUM_CH-1:0][BYTE_W-1:0]  src_rb,
  input  logic [NUM_CH-1:0][BYTE_W-1:0]  dst_rb,
  input  logic [NUM_CH-1:0][BYTE_W-1:0]  data_rb,
  input  logic [NUM_CH-1:0]              flag_rb,
  output logic [NUM_CH-1:0]              src_we,
  output logic [NUM_CH-1:0]              dst_we,
  output logic [NUM_CH-1:0]              data_we,
  output logic [NUM_CH-1:0]              data_rd,
  output logic [BYTE_W-1:0]              cpu_rdata
);
  logic [CH_W-1:0] ch_sel;
  reg_e            reg_sel;

  assign ch_sel  = cpu_addr[ADDR_W-1:2];
  assign reg_sel = reg_e'(cpu_addr[1:0]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    logic hit;
    assign hit        = (ch_sel == CH_W'(c));
    assign src_we[c]  = cpu_we && hit && (reg_sel == REG_SRC);
    assign dst_we[c]  = cpu_we && hit && (reg_sel == REG_DST);
    assign data_we[c] = cpu_we && hit && (reg_sel == REG_DATA);
    assign data_rd[c] = cpu_re && hit && (reg_sel == REG_DATA);
  end

  logic [BYTE_W-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (int'(ch_sel) < NUM_CH) begin
      case (reg_sel)
        REG_SRC:  rd_val = src_rb[ch_sel];
        REG_DST:  rd_val = dst_rb[ch_sel];
        REG_DATA: rd_val = data_rb[ch_sel];
        REG_STAT: rd_val = {{(BYTE_W-1){1'b0}}, flag_rb[ch_sel]};
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cpu_rdata <= '0;
    else if (cpu_re) cpu_rdata <= rd_val;
  end

  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !cpu_re |=> $stable(cpu_rdata));
endmodule

// File: rtl/slot_xfer_unit.sv
module slot_xfer_unit
  import xfer_pkg::*;
#(
  parameter  int NUM_CH    = 2,
  parameter  int NUM_SLOTS = 32,
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W    = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic [SLOT_W-1:0] slot_num,
  input  logic [BIT_W-1:0]  bit_num,
  input  logic              trk_rx,
  input  logic              lin_rx,
  output logic              trk_tx,
  output logic              trk_oe,
  output logic              lin_tx,
  output logic              lin_oe,
  input  logic              cpu_we,
  input  logic              cpu_re,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BYTE_W-1:0] cpu_wdata,
  output logic [BYTE_W-1:0] cpu_rdata
);
  logic [NUM_CH-1:0]             src_we, dst_we, data_we, data_rd;
  logic [NUM_CH-1:0]             cap_flag, tx_bit, tx_act, tx_if;
  logic [NUM_CH-1:0][BYTE_W-1:0] src_rb, dst_rb, data_rb;

  xfer_host_if #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W),
    .ADDR_W (ADDR_W)
  ) u_host (
    .clk       (clk),
    .rst       (rst),
    .cpu_we    (cpu_we),
    .cpu_re    (cpu_re),
    .cpu_addr  (cpu_addr),
    .src_rb    (src_rb),
    .dst_rb    (dst_rb),
    .data_rb   (data_rb),
    .flag_rb   (cap_flag),
    .src_we    (src_we),
    .dst_we    (dst_we),
    .data_we   (data_we),
    .data_rd   (data_rd),
    .cpu_rdata (cpu_rdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    xfer_channel #(.SLOT_W(SLOT_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .bit_tick (bit_tick),
      .slot_num (slot_num),
      .bit_num  (bit_num),
      .trk_rx   (trk_rx),
      .lin_rx   (lin_rx),
      .src_we   (src_we[c]),
      .dst_we   (dst_we[c]),
      .data_we  (data_we[c]),
      .data_rd  (data_rd[c]),
      .wdata    (cpu_wdata),
      .src_rb   (src_rb[c]),
      .dst_rb   (dst_rb[c]),
      .data_q   (data_rb[c]),
      .cap_flag (cap_flag[c]),
      .tx_bit   (tx_bit[c]),
      .tx_act   (tx_act[c]),
      .tx_if    (tx_if[c])
    );
  end

  xfer_tx_merge #(.NUM_CH(NUM_CH)) u_merge (
    .tx_bit (tx_bit),
    .tx_act (tx_act),
    .tx_if  (tx_if),
    .trk_tx (trk_tx),
    .trk_oe (trk_oe),
    .lin_tx (lin_tx),
    .lin_oe (lin_oe)
  );

  a_r1_oe_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (!trk_oe && !lin_oe));
endmodule

// File: tb/slot_xfer_unit_test.sv
module slot_xfer_unit_test;
  localparam int SRC = 0, DST = 1, DAT = 2, STA = 3;
  localparam logic [7:0] EN = 8'h40, LINE = 8'h80;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1, bit_tick = 1'b0, trk_rx = 1'b0, lin_rx = 1'b0;
  logic [4:0] slot_num = '0;
  logic [2:0] bit_num = '0;
  logic       cpu_we = 1'b0, cpu_re = 1'b0;
  logic [2:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic       trk_tx, trk_oe, lin_tx, lin_oe;
  logic [7:0] cpu_rdata;

  slot_xfer_unit uut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .slot_num(slot_num), .bit_num(bit_num),
    .trk_rx(trk_rx), .lin_rx(lin_rx), .trk_tx(trk_tx), .trk_oe(trk_oe),
    .lin_tx(lin_tx), .lin_oe(lin_oe), .cpu_we(cpu_we), .cpu_re(cpu_re),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  int   n_chk = 0, n_fail = 0;
  int   cur_frame = 0, cur_slot = 0, cur_bit = 0;
  bit   run_frm = 1'b0, done = 1'b0;
  event ev_tick;

  // Scoreboard queues, index 0 trunk, 1 line: {slot[4:0], byte[7:0]}
  logic [12:0] q_trk[$], q_lin[$];
  string       t_trk[$], t_lin[$];
  logic [7:0]  acc[2];
  int          cnt[2];

  function automatic logic [7:0] trk_byte(int f, int s);
    return 8'((f * 91 + s * 37 + 92) & 255);
  endfunction
  function automatic logic [7:0] lin_byte(int f, int s);
    return 8'(((f * 23) ^ (s * 53)) + 25);
  endfunction

  task automatic check8(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic expect_byte(int ifc, int s, logic [7:0] b, string tag);
    if (ifc == 0) begin q_trk.push_back({5'(s), b}); t_trk.push_back(tag); end
    else          begin q_lin.push_back({5'(s), b}); t_lin.push_back(tag); end
  endtask

  task automatic monitor(int i, logic oe, logic d, int s, int b);
    logic [12:0] e;
    string       tg;
    bit          got;
    if (oe) begin
      if (b == 0) begin acc[i] = '0; cnt[i] = 0; end
      acc[i] = {acc[i][6:0], d};
      cnt[i]++;
      if (b == 7) begin
        got = 1'b0;
        if (i == 0 && q_trk.size() > 0) begin e = q_trk.pop_front(); tg = t_trk.pop_front(); got = 1'b1; end
        else if (i == 1 && q_lin.size() > 0) begin e = q_lin.pop_front(); tg = t_lin.pop_front(); got = 1'b1; end
        n_chk++;
        if (!got) begin
          n_fail++;
          $display("FAIL R8/R4 unexpected byte on if%0d slot %0d: got %02h expected none", i, s, acc[i]);
        end else if (cnt[i] != 8 || int'(e[12:8]) != s || acc[i] !== e[7:0]) begin
          n_fail++;
          $display("FAIL %s if%0d slot %0d bits %0d: got %02h expected %02h in slot %0d",
                   tg, i, s, cnt[i], acc[i], e[7:0], e[12:8]);
        end
      end
    end
  endtask

  // Framer model plus output monitor: 4 clocks per bit, 32 slots of 8 bits
  initial begin
    logic [7:0] tb_v, lb_v;
    wait (run_frm);
    forever begin
      for (int s = 0; s < 32; s++) begin
        for (int b = 0; b < 8; b++) begin
          @(negedge clk);
          tb_v = trk_byte(cur_frame, s);
          lb_v = lin_byte(cur_frame, s);
          slot_num = 5'(s);
          bit_num  = 3'(b);
          trk_rx   = tb_v[7-b];
          lin_rx   = lb_v[7-b];
          bit_tick = 1'b1;
          cur_slot = s;
          cur_bit  = b;
          ->ev_tick;
          @(negedge clk);
          bit_tick = 1'b0;
          monitor(0, trk_oe, trk_tx, s, b);
          monitor(1, lin_oe, lin_tx, s, b);
          repeat (2) @(negedge clk);
        end
      end
      cur_frame++;
    end
  end

  task automatic wait_pos(int f, int s, int b);
    do @(ev_tick); while (!(cur_frame == f && cur_slot == s && cur_bit == b));
  endtask

  task automatic cpu_write(int ch, int r, logic [7:0] v);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = 3'(ch * 4 + r); cpu_wdata = v;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_read_now(int ch, int r, output logic [7:0] v);
    cpu_re = 1'b1; cpu_addr = 3'(ch * 4 + r);
    @(negedge clk);
    cpu_re = 1'b0;
    v = cpu_rdata;
  endtask

  task automatic cpu_read(int ch, int r, output logic [7:0] v);
    @(negedge clk);
    cpu_read_now(ch, r, v);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1..: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    int f0, g0, h0, k0, m0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check8("R1", "trk_oe", {7'b0, trk_oe}, 8'h00);
    check8("R1", "lin_oe", {7'b0, lin_oe}, 8'h00);
    check8("R1", "cpu_rdata", cpu_rdata, 8'h00);
    cpu_read(0, STA, v); check8("R1", "ch0 status", v, 8'h00);
    cpu_read(1, DAT, v); check8("R1", "ch1 data", v, 8'h00);
    cpu_read(1, SRC, v); check8("R1", "ch1 source", v, 8'h00);
    run_frm = 1'b1;

    // R3/R5: trunk slot 3 to line slot 10 on channel 0
    f0 = cur_frame + 1;
    expect_byte(1, 10, trk_byte(f0, 3), "R3");
    expect_byte(1, 10, trk_byte(f0 + 1, 3), "R5");
    wait_pos(f0, 0, 0);
    cpu_write(0, DST, LINE | 8'd10);
    cpu_write(0, SRC, EN | 8'd3);
    cpu_read(0, DST, v); check8("R2", "ch0 dest readback", v, 8'h8A);
    cpu_read(0, SRC, v); check8("R2", "ch0 source readback", v, 8'h43);
    wait_pos(f0 + 2, 0, 0);
    cpu_write(0, SRC, 8'd3);
    wait_pos(f0 + 3, 5, 0);
    cpu_read(0, STA, v); check8("R3", "flag after capture", v, 8'h01);
    cpu_read(0, DAT, v); check8("R8", "data frozen while off", v, trk_byte(f0 + 1, 3));
    cpu_read(0, STA, v); check8("R9", "flag after read", v, 8'h00);

    // R7: line slot 20 to trunk slot 5 on channel 1
    g0 = cur_frame + 1;
    expect_byte(0, 5, 8'h00, "R7");
    expect_byte(0, 5, lin_byte(g0, 20), "R7");
    expect_byte(0, 5, lin_byte(g0 + 1, 20), "R7");
    wait_pos(g0, 0, 0);
    cpu_write(1, DST, 8'd5);
    cpu_write(1, SRC, LINE | EN | 8'd20);
    wait_pos(g0 + 3, 0, 0);
    cpu_write(1, SRC, LINE | 8'd20);

    // R6: processor overwrite between capture and transmit
    h0 = cur_frame + 1;
    expect_byte(0, 30, 8'h5A, "R6");
    expect_byte(0, 30, trk_byte(h0 + 1, 4), "R3");
    wait_pos(h0, 0, 0);
    cpu_write(0, DST, 8'd30);
    cpu_write(0, SRC, EN | 8'd4);
    wait_pos(h0, 6, 0);
    cpu_write(0, DAT, 8'h5A);
    wait_pos(h0 + 2, 0, 0);
    cpu_write(0, SRC, 8'd4);

    // R10: both channels at slot 15, first on separate highways, then colliding
    k0 = cur_frame + 1;
    expect_byte(1, 15, trk_byte(k0, 7), "R5");
    expect_byte(0, 15, lin_byte(k0, 9), "R10");
    expect_byte(1, 15, trk_byte(k0 + 1, 7), "R10");
    wait_pos(k0, 0, 0);
    cpu_write(0, DST, LINE | 8'd15);
    cpu_write(1, DST, 8'd15);
    cpu_write(0, SRC, EN | 8'd7);
    cpu_write(1, SRC, LINE | EN | 8'd9);
    wait_pos(k0 + 1, 0, 0);
    cpu_write(1, DST, LINE | 8'd15);
    wait_pos(k0 + 2, 0, 0);
    cpu_write(0, SRC, 8'd7);
    cpu_write(1, SRC, LINE | 8'd9);
    cpu_read(1, DAT, v); check8("R10", "ch1 own capture", v, lin_byte(k0 + 1, 9));

    // R9: read in the same clock as the capture strobe
    m0 = cur_frame + 1;
    expect_byte(0, 20, trk_byte(m0, 12), "R4");
    expect_byte(0, 20, trk_byte(m0 + 1, 12), "R4");
    wait_pos(m0, 0, 0);
    cpu_write(0, DST, 8'd20);
    cpu_write(0, SRC, EN | 8'd12);
    wait_pos(m0 + 1, 12, 7);
    cpu_read_now(0, DAT, v); check8("R9", "old byte on colliding read", v, trk_byte(m0, 12));
    cpu_read(0, STA, v);     check8("R9", "flag kept on colliding read", v, 8'h01);
    cpu_read(0, DAT, v);     check8("R3", "new byte", v, trk_byte(m0 + 1, 12));
    cpu_read(0, STA, v);     check8("R9", "flag cleared", v, 8'h00);
    wait_pos(m0 + 2, 0, 0);
    cpu_write(0, SRC, 8'd12);

    wait_pos(m0 + 3, 0, 0);
    check8("R4", "trunk bytes left unsent", 8'(q_trk.size()), 8'h00);
    check8("R4", "line bytes left unsent", 8'(q_lin.size()), 8'h00);
    done = 1'b1;
    finish_run();
  end
endmodule